// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Data Store Controller

This block connects a CPU register bus to a small byte-addressed nonvolatile data array, which is modelled here as a register array. Software reaches the array indirectly through four bus-visible registers. These are an address register, a data register, a control register and a completion flag register. A read takes one cycle. A write runs for a fixed number of cycles: the location is erased and then reprogrammed as one timed operation, and no further software action is needed.

A write begins only when two conditions hold. Software must have set the write-enable bit beforehand, and an external permit input must be high. The permit input reports that the required unlock sequence was completed elsewhere. The read-start and write-start bits can be set by software but never cleared by it; hardware clears them. A warm reset (external, watchdog or brown-out) that arrives during a write cuts the write short and sets an error bit. The address and data registers keep their values, so software can repeat the write.

Top module: `dee_ctrl`

## Requirements
- R1: Reading register select 2 (control) returns bit 3 = write-error, bit 2 = write-enable, bit 1 = write-start, bit 0 = read-start, and 0 in bits 7..4. After power-up reset, the control byte, address register, data register, completion flag, busy_o and irq_o are all 0.
- R2: Writing the control register with bit 0 set, while no write is busy, makes read-start read 1 for exactly one cycle. On the next clock edge the data register (select 1) loads the array byte at the address register (select 0).
- R3: Writing 0 to read-start or write-start through the control register does not clear them. While a write is busy, write-start keeps reading 1.
- R4: Write-start becomes 1 only when all three of these hold: write-enable is already 1 before the control write, unlock_ok_i is high, and no write is busy. If any of them fails, write-start stays 0 and busy_o stays 0.
- R5: Once write-start is set, busy_o is high for exactly WRITE_CYCLES cycles. When the write ends, the array location holds the data register value and write-start reads 0.
- R6: When a write completes normally, the completion flag (select 3, bit 0) and irq_o become 1. They stay 1 until software writes select 3 with bit 0 = 0. Writing bit 0 = 1 leaves the flag unchanged.
- R7: Clearing write-enable while a write is busy does not abort the write. The array is still updated.
- R8: If warm_rst_i is high during a busy write, write-error becomes 1, busy_o drops and the array location is left unchanged. The address and data registers keep their values. A write that completes normally clears write-error to 0.
- R9: Write-enable is cleared only by power-up reset (rst_ni) or by software. warm_rst_i leaves it unchanged.
- R10: While a write is busy, bus writes to the address and data registers are ignored, and a read-start request is ignored.
- R11: With MEM_BYTES = 128, an address with bit 7 = 1 is out of range. A read of it loads 0x00, and a write to it leaves the array unchanged. With MEM_BYTES = 256, all eight address bits select a location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-up reset, active low, asynchronous |
| warm_rst_i | input | 1 | Synchronous warm reset (external, watchdog, brown-out) |
| reg_sel_i | input | 2 | Register select: 0 address, 1 data, 2 control, 3 completion flag |
| wr_en_i | input | 1 | Bus write strobe for the selected register |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Selected register value |
| unlock_ok_i | input | 1 | Unlock sequence completed; permits write-start |
| busy_o | output | 1 | A write is in progress |
| irq_o | output | 1 | Write-complete interrupt flag |

## Verification
The stimulus table writes a spread of addresses and data values and reads each one back: low and mid addresses, the top in-range address, and addresses with bit 7 set. Running it against a 256-byte instance and a 128-byte instance at the same time separates correct full-width decoding from correct out-of-range handling. Directed sequences then try each way a write can be refused or disturbed: write-enable absent, permit absent, bus writes while busy, write-enable cleared while busy, and a warm reset mid-write. Together they tell a write that starts and finishes correctly apart from one that is blocked, aborted or corrupted.

// File: rtl/dee_pkg.sv
package dee_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_FLAG = 2'd3
  } reg_sel_e;

  localparam int unsigned CB_RD   = 0;
  localparam int unsigned CB_WR   = 1;
  localparam int unsigned CB_WREN = 2;
  localparam int unsigned CB_ERR  = 3;
endpackage

// File: rtl/dee_wtimer.sv
module dee_wtimer #(
  parameter int unsigned WRITE_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i || !run_i || done_o) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dee_array.sv
module dee_array #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] mem_q [DEPTH];

  assign rdata_o = mem_q[idx_i];

  // erase+program modelled as one byte update at the end of the timed write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= 8'h00;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/dee_ctrl.sv
module dee_ctrl
  import dee_pkg::*;
#(
  parameter int unsigned MEM_BYTES    = 256,
  parameter int unsigned WRITE_CYCLES = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       warm_rst_i,
  input  logic [1:0] reg_sel_i,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       unlock_ok_i,
  output logic       busy_o,
  output logic       irq_o
);
  localparam int unsigned IDX_W = $clog2(MEM_BYTES);

  logic [7:0] addr_q, data_q, arr_rdata;
  logic       rd_q, wr_q, wren_q, err_q, flag_q;
  logic       wdone, in_range;
  logic       addr_we, data_we, ctrl_we, flag_we;

  assign addr_we  = wr_en_i && (reg_sel_i == SEL_ADDR);
  assign data_we  = wr_en_i && (reg_sel_i == SEL_DATA);
  assign ctrl_we  = wr_en_i && (reg_sel_i == SEL_CTRL);
  assign flag_we  = wr_en_i && (reg_sel_i == SEL_FLAG);
  assign in_range = ({1'b0, addr_q} < 9'(MEM_BYTES));

  dee_wtimer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (warm_rst_i),
    .run_i  (wr_q),
    .done_o (wdone)
  );

  dee_array #(.DEPTH(MEM_BYTES), .IDX_W(IDX_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wdone && in_range && !warm_rst_i),
    .idx_i   (addr_q[IDX_W-1:0]),
    .wdata_i (data_q),
    .rdata_o (arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      wren_q <= 1'b0;
      err_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (warm_rst_i) begin
      // addr/data/wren survive; an interrupted write is flagged
      if (wr_q) err_q <= 1'b1;
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      if (rd_q) begin
        rd_q   <= 1'b0;
        data_q <= in_range ? arr_rdata : 8'h00;
      end else if (data_we && !wr_q) begin
        data_q <= wdata_i;
      end
      if (addr_we && !wr_q) addr_q <= wdata_i;
      if (ctrl_we) begin
        wren_q <= wdata_i[CB_WREN];
        err_q  <= wdata_i[CB_ERR];
        if (wdata_i[CB_RD] && !wr_q) rd_q <= 1'b1;
        if (wdata_i[CB_WR] && wren_q && unlock_ok_i && !wr_q) wr_q <= 1'b1;
      end
      if (flag_we && !wdata_i[0]) flag_q <= 1'b0;
      if (wdone) begin
        wr_q   <= 1'b0;
        flag_q <= 1'b1;
        err_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (reg_sel_i)
      SEL_ADDR: rdata_o = addr_q;
      SEL_DATA: rdata_o = data_q;
      SEL_CTRL: rdata_o = {4'b0000, err_q, wren_q, wr_q, rd_q};
      default:  rdata_o = {7'b0, flag_q};
    endcase
  end

  assign busy_o = wr_q;
  assign irq_o  = flag_q;
endmodule

// File: rtl/dee_ctrl_chk.sv
module dee_ctrl_chk
  import dee_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 20
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       warm_rst_i,
  input logic [1:0] reg_sel_i,
  input logic       wr_en_i,
  input logic [7:0] rdata_o,
  input logic       busy_o,
  input logic       irq_o,
  input logic [7:0] addr_q,
  input logic       rd_q,
  input logic       wren_q,
  input logic       err_q
);
  logic [15:0] busy_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len_q <= '0;
    else if (busy_o) busy_len_q <= busy_len_q + 1'b1;
    else             busy_len_q <= '0;
  end

  p_ctrl_upper_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == SEL_CTRL) |-> (rdata_o[7:4] == 4'h0));

  p_rd_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |=> !rd_q);

  p_wr_needs_wren_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wren_q));

  p_busy_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(warm_rst_i)) |-> (busy_len_q == 16'(WRITE_CYCLES)));

  p_done_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(warm_rst_i)) |-> irq_o);

  p_warm_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_rst_i && busy_o) |=> (err_q && !busy_o));

  p_warm_wren_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_rst_i && !(wr_en_i && reg_sel_i == SEL_CTRL)) |=> $stable(wren_q));

  p_addr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_en_i && reg_sel_i == SEL_ADDR) |=> $stable(addr_q));
endmodule

bind dee_ctrl dee_ctrl_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (.*);

// File: tb/dee_ctrl_test.sv
module dee_ctrl_test;
  localparam int unsigned WC = 12;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       warm_rst_i = 1'b0;
  logic [1:0] reg_sel_i = 2'd0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic       unlock_ok_i = 1'b1;
  logic [7:0] rdata_o, rdata_s;
  logic       busy_o, busy_s, irq_o, irq_s;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  dee_ctrl #(.MEM_BYTES(256), .WRITE_CYCLES(WC)) uut (
    .clk_i, .rst_ni, .warm_rst_i, .reg_sel_i, .wr_en_i, .wdata_i,
    .rdata_o, .unlock_ok_i, .busy_o, .irq_o
  );

  dee_ctrl #(.MEM_BYTES(128), .WRITE_CYCLES(WC)) uut_small (
    .clk_i, .rst_ni, .warm_rst_i, .reg_sel_i, .wr_en_i, .wdata_i,
    .rdata_o(rdata_s), .unlock_ok_i, .busy_o(busy_s), .irq_o(irq_s)
  );

  // {addr, data}
  localparam logic [15:0] VEC [6] = '{
    16'h00_A5, 16'h01_3C, 16'h45_00, 16'h7F_FF, 16'h80_5A, 16'hFF_C3
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk_i);
    reg_sel_i = sel; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] sel, output logic [7:0] v, output logic [7:0] vs);
    reg_sel_i = sel;
    #1;
    v = rdata_o; vs = rdata_s;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy_o) begin cyc++; @(negedge clk_i); end
  endtask

  task automatic do_read(logic [7:0] a, output logic [7:0] v, output logic [7:0] vs);
    bus_wr(2'd0, a);
    bus_wr(2'd2, 8'h01);
    @(negedge clk_i);
    rd_reg(2'd1, v, vs);
  endtask

  initial begin
    logic [7:0] v, vs;
    int cyc;
    #20 rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R9 reset state
    rd_reg(2'd2, v, vs); chk("R1 ctrl reset", v, 0);
    rd_reg(2'd0, v, vs); chk("R1 addr reset", v, 0);
    rd_reg(2'd1, v, vs); chk("R1 data reset", v, 0);
    rd_reg(2'd3, v, vs); chk("R1 flag reset", v, 0);
    chk("R1 busy reset", busy_o, 0);
    chk("R9 irq reset", irq_o, 0);

    // table: write, time, read back in both sizes
    foreach (VEC[i]) begin
      logic [7:0] a, d;
      a = VEC[i][15:8]; d = VEC[i][7:0];
      bus_wr(2'd0, a); bus_wr(2'd1, d);
      bus_wr(2'd2, 8'h04); bus_wr(2'd2, 8'h06);
      wait_idle(cyc);
      chk("R5 busy length", cyc, WC);
      rd_reg(2'd2, v, vs); chk("R5 wr cleared", v, 8'h04);
      chk("R6 irq after write", irq_o, 1);
      bus_wr(2'd1, 8'h66);
      do_read(a, v, vs);
      chk("R2 R5 readback 256", v, d);
      chk("R11 readback 128", vs, (a[7] ? 8'h00 : d));
    end

    // R6 flag clear
    rd_reg(2'd3, v, vs); chk("R6 flag set", v, 1);
    bus_wr(2'd3, 8'h01);
    rd_reg(2'd3, v, vs); chk("R6 flag kept on 1", v, 1);
    bus_wr(2'd3, 8'h00);
    rd_reg(2'd3, v, vs); chk("R6 flag cleared", v, 0);
    chk("R6 irq cleared", irq_o, 0);

    // R2 read-start lasts one cycle
    bus_wr(2'd2, 8'h01);
    rd_reg(2'd2, v, vs); chk("R2 rd set", v, 8'h01);
    @(negedge clk_i);
    rd_reg(2'd2, v, vs); chk("R2 rd self-clears", v, 8'h00);

    // R4 refused starts
    bus_wr(2'd2, 8'h02);
    chk("R4 no wren busy", busy_o, 0);
    rd_reg(2'd2, v, vs); chk("R4 no wren ctrl", v, 8'h00);
    bus_wr(2'd2, 8'h04);
    unlock_ok_i = 1'b0;
    bus_wr(2'd2, 8'h06);
    chk("R4 no permit busy", busy_o, 0);
    rd_reg(2'd2, v, vs); chk("R4 no permit ctrl", v, 8'h04);
    unlock_ok_i = 1'b1;

    // R3 R7 R10 during busy
    bus_wr(2'd0, 8'h10); bus_wr(2'd1, 8'h77);
    bus_wr(2'd2, 8'h04); bus_wr(2'd2, 8'h06);
    bus_wr(2'd2, 8'h04);
    rd_reg(2'd2, v, vs); chk("R3 wr not cleared", v, 8'h06);
    bus_wr(2'd0, 8'h20); bus_wr(2'd1, 8'h11);
    rd_reg(2'd0, v, vs); chk("R10 addr held", v, 8'h10);
    rd_reg(2'd1, v, vs); chk("R10 data held", v, 8'h77);
    bus_wr(2'd2, 8'h01);
    rd_reg(2'd2, v, vs); chk("R10 R7 rd ignored wren off", v, 8'h02);
    chk("R7 still busy", busy_o, 1);
    wait_idle(cyc);
    do_read(8'h10, v, vs); chk("R7 write landed", v, 8'h77);

    // R8 R9 warm reset mid-write
    bus_wr(2'd1, 8'h99);
    bus_wr(2'd2, 8'h04); bus_wr(2'd2, 8'h06);
    @(negedge clk_i); @(negedge clk_i);
    warm_rst_i = 1'b1;
    @(negedge clk_i);
    warm_rst_i = 1'b0;
    chk("R8 busy dropped", busy_o, 0);
    rd_reg(2'd2, v, vs); chk("R8 R9 err set wren kept", v, 8'h0C);
    rd_reg(2'd0, v, vs); chk("R8 addr kept", v, 8'h10);
    rd_reg(2'd1, v, vs); chk("R8 data kept", v, 8'h99);
    bus_wr(2'd2, 8'h0D);
    @(negedge clk_i);
    rd_reg(2'd1, v, vs); chk("R8 array unchanged", v, 8'h77);
    bus_wr(2'd1, 8'h99);
    bus_wr(2'd2, 8'h0E);
    wait_idle(cyc);
    rd_reg(2'd2, v, vs); chk("R8 err cleared on completion", v, 8'h04);
    do_read(8'h10, v, vs); chk("R8 retry landed", v, 8'h99);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule